// File: doc/BRIEF.md
# Supercapacitor Stack Balancing Controller

This block governs charge equalisation across a series string of five supercapacitor cells. Every cell has an external resistive bypass load that the block may switch on to bleed that cell down. The block watches the five digitised cell voltages and the signed pack current, and it also reads a full-charge flag and a stack-mode configuration bit. From these it decides whether equalisation should run. When it runs, the block switches on the bypass of each cell that sits above a programmable level.

The block works in repeating cycles. Each cycle opens with a measurement window, during which every bypass load is released so that the cell readings are not disturbed. The decision is taken from the readings present on the last tick of that window, and it then holds until the next window. Separate restart and stop spread thresholds give start/stop hysteresis. Equalisation stays locked out until a one-time arm pulse has been seen, and it is forced off whenever stack mode is selected.

Top module: `cap_stack_balancer`

## Requirements
- R1: A synchronous reset clears the arm latch and the active state, and drives every bypass output and balActive low.
- R2: Equalisation never starts before a one-cycle armCmd pulse has been seen. Once the pulse is seen, the arm stays latched until reset.
- R3: While stackMode is 1, balActive and all bypass outputs are low from the next clock edge onward. The arm latch is kept.
- R4: When idle, a decision turns equalisation on only if all of the following hold: spread (highest cell minus lowest cell) is at least the effective restart threshold; the current exceeds chgCurThresh or fullCharge is 1; and the discharge condition of R5 is false.
- R5: When active, a decision turns equalisation off if the spread is below spreadMin or if the discharge magnitude (minus packCurrent) exceeds dsgCurThresh.
- R6: When active, a spread in the range from spreadMin to just below the restart threshold keeps equalisation on. When idle, the same spread does not start it.
- R7: If spreadRestart is programmed below spreadMin, the effective restart threshold is spreadMin.
- R8: After a decision that leaves equalisation on, the bypass of cell i is on exactly when that cell's voltage is strictly greater than balThresh. Cell 0 (cellVolt[15:0], the bottom of the stack) drives bypassLowest, and cells 1 to 4 drive bypassUpper[0] to bypassUpper[3]. When equalisation is off, every bypass output is low.
- R9: The tick counter runs from 0 to P-1, with W = max(measWindow,1) and P = max(cyclePeriod, W+1). The decision is taken only on the edge that ends tick W-1, and voltages that change at any other time do not affect the outputs until that edge.
- R10: Every bypass output is low on ticks 0 to W-1 of each cycle, including while equalisation is on.
- R11: packCurrent is two's complement milliamps, with positive meaning charging. Voltages and thresholds are unsigned millivolts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| armCmd | input | 1 | One-shot arm pulse that enables equalisation |
| stackMode | input | 1 | Configuration bit; 1 forces equalisation off |
| fullCharge | input | 1 | Full-charge flag |
| cellVolt | input | 80 | Five 16-bit cell voltages, cell 0 in bits 15:0 |
| packCurrent | input | 16 | Signed pack current in mA |
| balThresh | input | 16 | Cell level above which a bypass may switch on |
| spreadMin | input | 16 | Stop spread threshold |
| spreadRestart | input | 16 | Restart spread threshold |
| chgCurThresh | input | 16 | Charge current threshold |
| dsgCurThresh | input | 16 | Discharge current magnitude threshold |
| cyclePeriod | input | 16 | Cycle length in ticks |
| measWindow | input | 16 | Measurement window length in ticks |
| bypassLowest | output | 1 | Bypass enable for the bottom cell |
| bypassUpper | output | 4 | Bypass enables for cells 1 to 4 |
| balActive | output | 1 | Equalisation active |

## Verification
The assertions watch several rules on every cycle. Every bypass is low inside the measurement window and whenever equalisation is idle. Stack mode clears the outputs on the next edge. balActive moves only on a decision edge. A decision whose spread is too small, or whose discharge current is too large, never leaves equalisation on. Only the bench's scenarios can show the things that depend on input history and exact values. These are the arm lock-out, the hysteresis band, the clamping of an inverted restart threshold, the strict above-threshold selection of each cell, and the fact that voltage changes in mid-cycle have no effect.

// File: rtl/cap_bal_pkg.sv
`timescale 1ns/1ps
package cap_bal_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic blank;      // measurement window: bypass released
    logic sampleStb;  // decision edge
    logic forceOff;   // stack mode: clear selection
    logic selectEn;   // decision result: equalisation on
  } ctl_strobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic spreadBelowMin;
    logic spreadAtRestart;
    logic chgOver;
    logic dsgOver;
  } dp_flags_t;

  typedef enum logic {BAL_OFF = 1'b0, BAL_ON = 1'b1} bal_state_t;

endpackage

// File: rtl/cap_bal_datapath.sv
`timescale 1ns/1ps
module cap_bal_datapath
  import cap_bal_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int VOLT_W    = 16,
  parameter int CUR_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  ctl_strobe_t                    ctl,
  input  logic [NUM_CELLS*VOLT_W-1:0]    cellVolt,
  input  logic signed [CUR_W-1:0]        packCurrent,
  input  logic [VOLT_W-1:0]              balThresh,
  input  logic [VOLT_W-1:0]              spreadMin,
  input  logic [VOLT_W-1:0]              spreadRestart,
  input  logic [CUR_W-1:0]               chgCurThresh,
  input  logic [CUR_W-1:0]               dsgCurThresh,
  output dp_flags_t                      flags,
  output logic [NUM_CELLS-1:0]           bypass
);

  localparam int EXT_W = CUR_W + 2;

  logic [VOLT_W-1:0]     cellArr [NUM_CELLS];
  logic [NUM_CELLS-1:0]  aboveMask;
  logic [NUM_CELLS-1:0]  selReg;
  logic [VOLT_W-1:0]     maxV, minV, spread, restartEff;
  logic signed [EXT_W-1:0] curExt, negCur, chgRef, dsgRef;

  genvar g;
  for (g = 0; g < NUM_CELLS; g++) begin : g_cell
    assign cellArr[g]   = cellVolt[g*VOLT_W +: VOLT_W];
    assign aboveMask[g] = cellArr[g] > balThresh;
  end

  // highest and lowest cell
  always_comb begin
    maxV = cellArr[0];
    minV = cellArr[0];
    for (int i = 1; i < NUM_CELLS; i++) begin
      if (cellArr[i] > maxV) maxV = cellArr[i];
      if (cellArr[i] < minV) minV = cellArr[i];
    end
  end

  assign spread     = maxV - minV;
  assign restartEff = (spreadRestart < spreadMin) ? spreadMin : spreadRestart;

  // widened signed current compares
  assign curExt = {{2{packCurrent[CUR_W-1]}}, packCurrent};
  assign negCur = -curExt;
  assign chgRef = {2'b00, chgCurThresh};
  assign dsgRef = {2'b00, dsgCurThresh};

  always_comb begin
    flags.spreadBelowMin  = spread < spreadMin;
    flags.spreadAtRestart = spread >= restartEff;
    flags.chgOver         = curExt > chgRef;
    flags.dsgOver         = negCur > dsgRef;
  end

  // selection register, updated on decision edges only
  always_ff @(posedge clk) begin
    if (rst || ctl.forceOff) begin
      selReg <= '0;
    end else if (ctl.sampleStb) begin
      selReg <= ctl.selectEn ? aboveMask : '0;
    end
  end

  assign bypass = ctl.blank ? '0 : selReg;

  AST_SEL_ABOVE_THRESH: assert property (@(posedge clk) disable iff (rst)
    (ctl.sampleStb && !ctl.forceOff && ctl.selectEn) |=> ((selReg & ~$past(aboveMask)) == '0)) // R8
    else $error("selection includes a cell not above threshold");

endmodule

// File: rtl/cap_bal_control.sv
`timescale 1ns/1ps
module cap_bal_control
  import cap_bal_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armCmd,
  input  logic              stackMode,
  input  logic              fullCharge,
  input  logic [CNT_W-1:0]  cyclePeriod,
  input  logic [CNT_W-1:0]  measWindow,
  input  dp_flags_t         flags,
  output ctl_strobe_t       ctl,
  output logic              balActive
);

  localparam int CW1 = CNT_W + 1;

  logic [CW1-1:0] winEff, perEff, tickCnt;
  logic           armed;
  logic           startOk, holdOk, nextOn;
  bal_state_t     balState;

  assign winEff = (measWindow == '0) ? CW1'(1) : {1'b0, measWindow};
  assign perEff = ({1'b0, cyclePeriod} > winEff) ? {1'b0, cyclePeriod} : winEff + CW1'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt <= '0;
    end else if (tickCnt >= perEff - CW1'(1)) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + CW1'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (armCmd) armed <= 1'b1;
  end

  assign startOk = armed && flags.spreadAtRestart && (flags.chgOver || fullCharge) && !flags.dsgOver;
  assign holdOk  = armed && !flags.spreadBelowMin && !flags.dsgOver;
  assign nextOn  = (balState == BAL_ON) ? holdOk : startOk;

  always_ff @(posedge clk) begin
    if (rst || stackMode) begin
      balState <= BAL_OFF;
    end else if (ctl.sampleStb) begin
      balState <= nextOn ? BAL_ON : BAL_OFF;
    end
  end

  always_comb begin
    ctl.blank     = tickCnt < winEff;
    ctl.sampleStb = tickCnt == (winEff - CW1'(1));
    ctl.forceOff  = stackMode;
    ctl.selectEn  = nextOn;
  end

  assign balActive = (balState == BAL_ON);

  AST_STOP_ON_SPREAD: assert property (@(posedge clk) disable iff (rst)
    (ctl.sampleStb && flags.spreadBelowMin) |=> !balActive) // R5
    else $error("active after spread below minimum");

  AST_STOP_ON_DSG: assert property (@(posedge clk) disable iff (rst)
    (ctl.sampleStb && flags.dsgOver) |=> !balActive) // R5
    else $error("active during discharge");

  AST_NO_START_LOW_SPREAD: assert property (@(posedge clk) disable iff (rst)
    (ctl.sampleStb && !balActive && !flags.spreadAtRestart) |=> !balActive) // R4
    else $error("started below restart spread");

  AST_DECIDE_AT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (!ctl.sampleStb && !stackMode) |=> $stable(balActive)) // R9
    else $error("state changed off a decision edge");

  AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!armed && !armCmd) |=> !balActive) // R2
    else $error("active while not armed");

endmodule

// File: rtl/cap_stack_balancer.sv
`timescale 1ns/1ps
module cap_stack_balancer
  import cap_bal_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int VOLT_W    = 16,
  parameter int CUR_W     = 16,
  parameter int CNT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         armCmd,
  input  logic                         stackMode,
  input  logic                         fullCharge,
  input  logic [NUM_CELLS*VOLT_W-1:0]  cellVolt,
  input  logic signed [CUR_W-1:0]      packCurrent,
  input  logic [VOLT_W-1:0]            balThresh,
  input  logic [VOLT_W-1:0]            spreadMin,
  input  logic [VOLT_W-1:0]            spreadRestart,
  input  logic [CUR_W-1:0]             chgCurThresh,
  input  logic [CUR_W-1:0]             dsgCurThresh,
  input  logic [CNT_W-1:0]             cyclePeriod,
  input  logic [CNT_W-1:0]             measWindow,
  output logic                         bypassLowest,
  output logic [NUM_CELLS-2:0]         bypassUpper,
  output logic                         balActive
);

  ctl_strobe_t          ctl;
  dp_flags_t            flags;
  logic [NUM_CELLS-1:0] bypass;

  cap_bal_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .armCmd(armCmd), .stackMode(stackMode),
    .fullCharge(fullCharge), .cyclePeriod(cyclePeriod), .measWindow(measWindow),
    .flags(flags), .ctl(ctl), .balActive(balActive)
  );

  cap_bal_datapath #(.NUM_CELLS(NUM_CELLS), .VOLT_W(VOLT_W), .CUR_W(CUR_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .cellVolt(cellVolt), .packCurrent(packCurrent),
    .balThresh(balThresh), .spreadMin(spreadMin), .spreadRestart(spreadRestart),
    .chgCurThresh(chgCurThresh), .dsgCurThresh(dsgCurThresh),
    .flags(flags), .bypass(bypass)
  );

  assign bypassLowest = bypass[0];
  assign bypassUpper  = bypass[NUM_CELLS-1:1];

  AST_BLANK_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ctl.blank |-> (bypass == '0)) // R10
    else $error("bypass on during measurement window");

  AST_STACK_FORCE_OFF: assert property (@(posedge clk) disable iff (rst)
    stackMode |=> (!balActive && bypass == '0)) // R3
    else $error("outputs on in stack mode");

  AST_IDLE_NO_BYPASS: assert property (@(posedge clk) disable iff (rst)
    !balActive |-> (bypass == '0)) // R8
    else $error("bypass on while idle");

endmodule

// File: tb/tb_cap_stack_balancer.sv
`timescale 1ns/1ps
module tb_cap_stack_balancer;

  localparam int WIN = 4;
  localparam int PER = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic armCmd = 1'b0, stackMode = 1'b0, fullCharge = 1'b0;
  logic [15:0] cv [5];
  logic [79:0] cellVolt;
  logic signed [15:0] packCurrent = '0;
  logic [15:0] balThresh = 16'd2500, spreadMin = 16'd50, spreadRestart = 16'd150;
  logic [15:0] chgCurThresh = 16'd100, dsgCurThresh = 16'd200;
  logic [15:0] cyclePeriod = 16'(PER), measWindow = 16'(WIN);
  logic bypassLowest, balActive;
  logic [3:0] bypassUpper;

  int checks = 0, fails = 0;
  string curTag = "R1";

  // reference model state
  int mCnt = 0;
  bit mArmed = 0, mActive = 0;
  logic [4:0] mSel = '0;
  bit started = 0;

  assign cellVolt = {cv[4], cv[3], cv[2], cv[1], cv[0]};

  always #2 clk = ~clk;

  cap_stack_balancer dut (
    .clk(clk), .rst(rst), .armCmd(armCmd), .stackMode(stackMode), .fullCharge(fullCharge),
    .cellVolt(cellVolt), .packCurrent(packCurrent), .balThresh(balThresh),
    .spreadMin(spreadMin), .spreadRestart(spreadRestart), .chgCurThresh(chgCurThresh),
    .dsgCurThresh(dsgCurThresh), .cyclePeriod(cyclePeriod), .measWindow(measWindow),
    .bypassLowest(bypassLowest), .bypassUpper(bypassUpper), .balActive(balActive)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int wEff, pEff, mx, mn, spr, rEff, cur, ct, dt, sMin, bt;
    bit nxt, dsg;
    logic [4:0] mask;
    started = 1;
    wEff = (measWindow == 0) ? 1 : int'(measWindow);
    pEff = (int'(cyclePeriod) > wEff) ? int'(cyclePeriod) : wEff + 1;
    if (rst) begin
      mCnt = 0; mArmed = 0; mActive = 0; mSel = '0;
    end else begin
      mx = 0; mn = 65535; mask = '0; bt = int'(balThresh);
      for (int i = 0; i < 5; i++) begin
        int v;
        v = int'(cv[i]);
        if (v > mx) mx = v;
        if (v < mn) mn = v;
        mask[i] = (v > bt);
      end
      spr  = mx - mn;
      sMin = int'(spreadMin);
      rEff = (int'(spreadRestart) < sMin) ? sMin : int'(spreadRestart);
      cur  = int'(packCurrent);
      ct   = int'(chgCurThresh);
      dt   = int'(dsgCurThresh);
      dsg  = (-cur > dt);
      if (stackMode) begin
        mActive = 0; mSel = '0;
      end else if (mCnt == wEff - 1) begin
        if (!mArmed)     nxt = 0;
        else if (mActive) nxt = (spr >= sMin) && !dsg;
        else             nxt = (spr >= rEff) && ((cur > ct) || fullCharge) && !dsg;
        mActive = nxt;
        mSel = nxt ? mask : '0;
      end
      if (armCmd) mArmed = 1;
      mCnt = (mCnt >= pEff - 1) ? 0 : mCnt + 1;
    end
  end

  // compare with the model on every falling edge
  always @(negedge clk) begin
    logic [4:0] expB, got;
    if (started) begin
      expB = (mCnt < WIN) ? 5'b0 : mSel;
      got  = {bypassUpper, bypassLowest};
      checks++;
      if (got !== expB || balActive !== mActive) begin
        fails++;
        $display("FAIL %s cycle model: active=%0b bypass=%b expected active=%0b bypass=%b",
                 curTag, balActive, got, mActive, expB);
      end
    end
  end

  task automatic checkNow(input string tag, input bit expAct, input logic [4:0] expByp);
    logic [4:0] got;
    got = {bypassUpper, bypassLowest};
    checks++;
    if (balActive !== expAct || got !== expByp) begin
      fails++;
      $display("FAIL %s: active=%0b bypass=%b expected active=%0b bypass=%b",
               tag, balActive, got, expAct, expByp);
    end
  endtask

  // wait for a fresh decision and land inside the balance phase
  task automatic toBalance();
    do @(negedge clk); while (mCnt != 0);
    do @(negedge clk); while (mCnt != WIN + 1);
  endtask

  task automatic setCells(input int a, input int b, input int c, input int d, input int e);
    cv[0] = 16'(a); cv[1] = 16'(b); cv[2] = 16'(c); cv[3] = 16'(d); cv[4] = 16'(e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL R9 watchdog: run not finished, expected completion");
    summary();
    $finish;
  end

  initial begin
    setCells(2600, 2450, 2450, 2450, 2700);
    packCurrent = 16'sd500;
    repeat (3) @(negedge clk);
    checkNow("R1", 1'b0, 5'b00000);
    rst = 1'b0;

    // not armed: spread and current would start it
    curTag = "R2";
    toBalance();
    checkNow("R2", 1'b0, 5'b00000);

    // arm with a single pulse, charging above threshold
    @(negedge clk) armCmd = 1'b1;
    @(negedge clk) armCmd = 1'b0;
    curTag = "R4";
    toBalance();
    checkNow("R4", 1'b1, 5'b10001);
    checkNow("R8", 1'b1, 5'b10001);

    // blanking inside the window while on
    curTag = "R10";
    do @(negedge clk); while (mCnt != 1);
    checkNow("R10", 1'b1, 5'b00000);

    // hysteresis band keeps it on; cell4 at threshold is not selected
    curTag = "R6";
    setCells(2550, 2450, 2450, 2450, 2500);
    toBalance();
    checkNow("R6", 1'b1, 5'b00001);

    // spread below minimum stops
    curTag = "R5";
    setCells(2480, 2450, 2450, 2450, 2450);
    toBalance();
    checkNow("R5", 1'b0, 5'b00000);

    // band spread does not start from idle
    curTag = "R6";
    setCells(2550, 2450, 2450, 2450, 2500);
    toBalance();
    checkNow("R6", 1'b0, 5'b00000);

    // full-charge flag starts with zero current
    curTag = "R4";
    packCurrent = 16'sd0; fullCharge = 1'b1;
    setCells(2600, 2450, 2450, 2450, 2700);
    toBalance();
    checkNow("R4", 1'b1, 5'b10001);

    // small discharge holds, large discharge stops
    curTag = "R11";
    packCurrent = -16'sd150;
    toBalance();
    checkNow("R11", 1'b1, 5'b10001);
    curTag = "R5";
    packCurrent = -16'sd300;
    toBalance();
    checkNow("R5", 1'b0, 5'b00000);

    // current equal to charge threshold does not start
    curTag = "R4";
    fullCharge = 1'b0; packCurrent = 16'sd100;
    toBalance();
    checkNow("R4", 1'b0, 5'b00000);

    // inverted restart threshold clamps to minimum
    curTag = "R7";
    packCurrent = 16'sd500; spreadRestart = 16'd20;
    setCells(2540, 2500, 2500, 2500, 2500);
    toBalance();
    checkNow("R7", 1'b0, 5'b00000);
    setCells(2560, 2500, 2500, 2500, 2500);
    toBalance();
    checkNow("R7", 1'b1, 5'b00001);

    // stack mode forces off on the next edge, arm is kept
    curTag = "R3";
    @(negedge clk) stackMode = 1'b1;
    @(negedge clk);
    checkNow("R3", 1'b0, 5'b00000);
    toBalance();
    checkNow("R3", 1'b0, 5'b00000);
    stackMode = 1'b0;
    curTag = "R2";
    toBalance();
    checkNow("R2", 1'b1, 5'b00001);

    // mid-cycle voltage change waits for the next decision
    curTag = "R9";
    setCells(2600, 2450, 2450, 2450, 2700);
    toBalance();
    checkNow("R9", 1'b1, 5'b10001);
    do @(negedge clk); while (mCnt != WIN + 3);
    cv[4] = 16'd2400;
    @(negedge clk);
    checkNow("R9", 1'b1, 5'b10001);
    toBalance();
    checkNow("R9", 1'b1, 5'b00001);

    // reset clears arm and state
    curTag = "R1";
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    checkNow("R1", 1'b0, 5'b00000);
    rst = 1'b0;
    toBalance();
    checkNow("R1", 1'b0, 5'b00000);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule